// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns each incoming message-signalled interrupt into one 64-byte record and writes it into a circular event queue in memory. A message arrives with its dword-aligned target address, its 32-bit data and the requester ID.

The low byte of the data selects an entry in a mapping table. Each entry holds a valid flag, a pending flag and the number of the target queue. Each queue has its own head and tail pointers, and all queues share one base address. When a message is accepted, the block issues a single full-line write command. The command carries the record address and a 512-bit line that holds a two-word record.

Messages are dropped without a write in three cases: the mapping is not valid, the entry's pending flag is still set from an earlier write, or the target queue is full. Software-side actions are presented as plain inputs: loading a mapping entry, clearing a pending flag and advancing a head pointer. The block evaluates one message at a time and shows this on a ready output, so no two pointer updates can race.

Top module: `msi_evq_writer`

## Requirements
- R1: After reset, `msg_ready` is 1, `wr_valid` is 0, every mapping entry is invalid, every pending flag is clear and every head and tail pointer is 0.
- R2: A message is taken on a rising edge where `msg_valid` and `msg_ready` are both 1. `msg_ready` is 0 for the following cycle. If the message is accepted, `wr_valid` is 1 for exactly the one cycle after the second rising edge, counting the capture edge as the first.
- R3: A message whose mapping entry is invalid produces no write and changes no pointer.
- R4: A message whose pending flag is set produces no write and leaves the tail unchanged. Pulsing `pend_clr` for that entry lets the next message through.
- R5: A queue is full when its 7-bit tail plus one, taken modulo 128, equals its head. A message aimed at a full queue is dropped. A head update that frees space lets the next message through.
- R6: The write address is `evq_base + queue*8192 + tail*64`. On an accepted write, the queue's tail advances by one and wraps from 127 to 0, and the entry's pending flag is set.
- R7: Bits 511:448 of the line hold the header word. Bit 63 is 0. Bits 62:56 are 7'b1011000 when address bits 63:32 are all zero, and 7'b1111000 otherwise. Bits 55:46 are 1. Bits 45:32 are address bits 15:2. Bits 31:16 are the requester ID. Bits 15:0 are data bits 15:0.
- R8: Bits 447:384 of the line hold address bits 63:16 in their upper 48 bits and data bits 31:16 in their lower 16 bits. Bits 383:0 are zero.
- R9: Every write has `wr_opcode` = 4'b1101, `wr_last` = 1, `wr_bytemask` = 0 and `wr_bank` = `wr_addr[8:6]`.
- R10: The mapping index is data bits 7:0 only. Two messages that differ only in their upper data bits use the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Block idle and able to take a message |
| msg_addr | input | 62 | MSI address bits 63:2 |
| msg_data | input | 32 | MSI data |
| msg_rid | input | 16 | Requester ID |
| evq_base | input | 64 | Common base address of the queues |
| map_we | input | 1 | Load one mapping entry |
| map_idx | input | MSI_W | Entry to load |
| map_valid | input | 1 | Valid flag to load |
| map_queue | input | QUEUE_W | Target queue to load |
| pend_clr | input | 1 | Clear one pending flag |
| pend_clr_idx | input | MSI_W | Entry whose pending flag is cleared |
| head_we | input | 1 | Load one head pointer |
| head_sel | input | QUEUE_W | Queue whose head is loaded |
| head_val | input | TAIL_W | New head value |
| wr_valid | output | 1 | Line write command present |
| wr_addr | output | 64 | Line write address |
| wr_data | output | 512 | Line data |
| wr_opcode | output | 4 | Write opcode |
| wr_last | output | 1 | Last-beat flag |
| wr_bytemask | output | 8 | Byte mask |
| wr_bank | output | 3 | Target bank |

## Verification
A message is driven at a falling edge and captured on the next rising edge. The bench checks `msg_ready` low at the following falling edge. It then samples the write command at the falling edge after the second rising edge, which is the only cycle in which `wr_valid` may be high for that message. Mapping loads, pending clears and head loads are each held for one rising edge before the next message is driven, so each one is visible to that message. Expected records, addresses and drop decisions come from a bench model of the table and pointers.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
  localparam int ADDR_W        = 64;
  localparam int DATA_W        = 32;
  localparam int RID_W         = 16;
  localparam int WORD_W        = 64;
  localparam int LINE_WORDS    = 8;
  localparam int LINE_W        = WORD_W * LINE_WORDS;
  localparam int LINE_SH       = 6;   // 64-byte records
  localparam int QSPAN_SH      = 13;  // 8 KiB per queue
  localparam int BANK_W        = 3;
  localparam int MASK_W        = 8;

  localparam logic [3:0] LINE_WR_OP = 4'b1101;
  localparam logic [6:0] HDR_NARROW = 7'b1011000;
  localparam logic [6:0] HDR_WIDE   = 7'b1111000;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EVAL = 1'b1
  } evq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:2] dw_addr;
    logic [DATA_W-1:0] data;
    logic [RID_W-1:0]  rid;
  } msi_msg_t;
endpackage

// File: rtl/msi_map_table.sv
module msi_map_table #(
  parameter int MSI_W   = 8,
  parameter int QUEUE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [MSI_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [QUEUE_W-1:0] cfg_queue,
  input  logic               clr_en,
  input  logic [MSI_W-1:0]   clr_idx,
  input  logic               set_en,
  input  logic [MSI_W-1:0]   set_idx,
  input  logic [MSI_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic               rd_pend,
  output logic [QUEUE_W-1:0] rd_queue
);
  localparam int NUM = 1 << MSI_W;

  logic [NUM-1:0]              valid_q, valid_d;
  logic [NUM-1:0]              pend_q, pend_d;
  logic [NUM-1:0][QUEUE_W-1:0] queue_q, queue_d;
  logic                        tbl_ce;

  assign tbl_ce = cfg_we | clr_en | set_en;

  always_comb begin
    valid_d = valid_q;
    queue_d = queue_q;
    pend_d  = pend_q;
    if (cfg_we) begin
      valid_d[cfg_idx] = cfg_valid;
      queue_d[cfg_idx] = cfg_queue;
    end
    if (clr_en) pend_d[clr_idx] = 1'b0;
    // a new write wins over a clear of the same entry
    if (set_en) pend_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      queue_q <= '0;
      pend_q  <= '0;
    end else if (tbl_ce) begin
      valid_q <= valid_d;
      queue_q <= queue_d;
      pend_q  <= pend_d;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_pend  = pend_q[rd_idx];
  assign rd_queue = queue_q[rd_idx];

  // R3
  map_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> valid_q[set_idx]);

  // R4
  pend_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !pend_q[set_idx]);
endmodule

// File: rtl/evq_ptr_file.sv
module evq_ptr_file #(
  parameter int QUEUE_W = 3,
  parameter int TAIL_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_we,
  input  logic [QUEUE_W-1:0] head_sel,
  input  logic [TAIL_W-1:0]  head_val,
  input  logic               inc_en,
  input  logic [QUEUE_W-1:0] inc_sel,
  input  logic [QUEUE_W-1:0] rd_sel,
  output logic [TAIL_W-1:0]  rd_tail,
  output logic               rd_full
);
  localparam int NQ = 1 << QUEUE_W;

  logic [TAIL_W-1:0] head_arr [NQ];
  logic [TAIL_W-1:0] tail_arr [NQ];
  logic [NQ-1:0]     full_arr;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    logic [TAIL_W-1:0] head_r, head_n, tail_r, tail_n;
    logic              head_ce, tail_ce;

    assign head_ce = head_we && (head_sel == QUEUE_W'(g));
    assign tail_ce = inc_en && (inc_sel == QUEUE_W'(g));
    assign head_n  = head_val;
    assign tail_n  = tail_r + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       head_r <= '0;
      else if (head_ce) head_r <= head_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tail_r <= '0;
      else if (tail_ce) tail_r <= tail_n;
    end

    assign head_arr[g] = head_r;
    assign tail_arr[g] = tail_r;
    assign full_arr[g] = (tail_n == head_r);
  end

  assign rd_tail = tail_arr[rd_sel];
  assign rd_full = full_arr[rd_sel];

  // R5
  no_full_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |-> !full_arr[inc_sel]);
endmodule

// File: rtl/evq_record_fmt.sv
module evq_record_fmt
  import msi_evq_pkg::*;
#(
  parameter int QUEUE_W = 3,
  parameter int TAIL_W  = 7
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [QUEUE_W-1:0] queue,
  input  logic [TAIL_W-1:0]  tail,
  input  msi_msg_t           msg,
  output logic [ADDR_W-1:0]  line_addr,
  output logic [LINE_W-1:0]  line_data,
  output logic [BANK_W-1:0]  line_bank
);
  logic [ADDR_W-1:0] q_off, t_off;
  logic [WORD_W-1:0] hdr_word, tail_word;
  logic [6:0]        fmt;

  assign q_off     = {{(ADDR_W-QUEUE_W-QSPAN_SH){1'b0}}, queue, {QSPAN_SH{1'b0}}};
  assign t_off     = {{(ADDR_W-TAIL_W-LINE_SH){1'b0}}, tail, {LINE_SH{1'b0}}};
  assign line_addr = base + q_off + t_off;
  assign line_bank = line_addr[LINE_SH+BANK_W-1:LINE_SH];

  assign fmt       = (msg.dw_addr[63:32] == '0) ? HDR_NARROW : HDR_WIDE;
  assign hdr_word  = {1'b0, fmt, 10'd1, msg.dw_addr[15:2], msg.rid, msg.data[15:0]};
  assign tail_word = {msg.dw_addr[63:16], msg.data[31:16]};

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    if (w == 0) begin : g_hdr
      assign line_data[LINE_W-1-w*WORD_W -: WORD_W] = hdr_word;
    end else if (w == 1) begin : g_tl
      assign line_data[LINE_W-1-w*WORD_W -: WORD_W] = tail_word;
    end else begin : g_zero
      assign line_data[LINE_W-1-w*WORD_W -: WORD_W] = '0;
    end
  end
endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
  import msi_evq_pkg::*;
#(
  parameter int MSI_W   = 8,
  parameter int QUEUE_W = 3,
  parameter int TAIL_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [ADDR_W-1:2]  msg_addr,
  input  logic [DATA_W-1:0]  msg_data,
  input  logic [RID_W-1:0]   msg_rid,
  input  logic [ADDR_W-1:0]  evq_base,
  input  logic               map_we,
  input  logic [MSI_W-1:0]   map_idx,
  input  logic               map_valid,
  input  logic [QUEUE_W-1:0] map_queue,
  input  logic               pend_clr,
  input  logic [MSI_W-1:0]   pend_clr_idx,
  input  logic               head_we,
  input  logic [QUEUE_W-1:0] head_sel,
  input  logic [TAIL_W-1:0]  head_val,
  output logic               wr_valid,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [LINE_W-1:0]  wr_data,
  output logic [3:0]         wr_opcode,
  output logic               wr_last,
  output logic [MASK_W-1:0]  wr_bytemask,
  output logic [BANK_W-1:0]  wr_bank
);
  evq_state_e         st_q, st_d;
  msi_msg_t           msg_q, msg_d;
  logic               cap_ce;
  logic               accept;
  logic [MSI_W-1:0]   msi_num;

  logic               ent_valid, ent_pend, q_full;
  logic [QUEUE_W-1:0] ent_queue;
  logic [TAIL_W-1:0]  q_tail;

  logic [ADDR_W-1:0]  fmt_addr;
  logic [LINE_W-1:0]  fmt_data;
  logic [BANK_W-1:0]  fmt_bank;

  logic               wr_valid_q, wr_valid_d;
  logic [ADDR_W-1:0]  wr_addr_q;
  logic [LINE_W-1:0]  wr_data_q;
  logic [BANK_W-1:0]  wr_bank_q;

  assign msg_d   = '{dw_addr: msg_addr, data: msg_data, rid: msg_rid};
  assign msi_num = msg_q.data[MSI_W-1:0];

  // next state
  always_comb begin
    st_d   = st_q;
    cap_ce = 1'b0;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (msg_valid) begin
          cap_ce = 1'b1;
          st_d   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        accept = ent_valid && !ent_pend && !q_full;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign wr_valid_d = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msg_q <= '0;
    else if (cap_ce) msg_q <= msg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_valid_q <= 1'b0;
    else        wr_valid_q <= wr_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_bank_q <= '0;
    end else if (accept) begin
      wr_addr_q <= fmt_addr;
      wr_data_q <= fmt_data;
      wr_bank_q <= fmt_bank;
    end
  end

  msi_map_table #(.MSI_W(MSI_W), .QUEUE_W(QUEUE_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (map_we),
    .cfg_idx   (map_idx),
    .cfg_valid (map_valid),
    .cfg_queue (map_queue),
    .clr_en    (pend_clr),
    .clr_idx   (pend_clr_idx),
    .set_en    (accept),
    .set_idx   (msi_num),
    .rd_idx    (msi_num),
    .rd_valid  (ent_valid),
    .rd_pend   (ent_pend),
    .rd_queue  (ent_queue)
  );

  evq_ptr_file #(.QUEUE_W(QUEUE_W), .TAIL_W(TAIL_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .head_we  (head_we),
    .head_sel (head_sel),
    .head_val (head_val),
    .inc_en   (accept),
    .inc_sel  (ent_queue),
    .rd_sel   (ent_queue),
    .rd_tail  (q_tail),
    .rd_full  (q_full)
  );

  evq_record_fmt #(.QUEUE_W(QUEUE_W), .TAIL_W(TAIL_W)) u_fmt (
    .base      (evq_base),
    .queue     (ent_queue),
    .tail      (q_tail),
    .msg       (msg_q),
    .line_addr (fmt_addr),
    .line_data (fmt_data),
    .line_bank (fmt_bank)
  );

  assign msg_ready   = (st_q == ST_IDLE);
  assign wr_valid    = wr_valid_q;
  assign wr_addr     = wr_addr_q;
  assign wr_data     = wr_data_q;
  assign wr_bank     = wr_bank_q;
  assign wr_opcode   = LINE_WR_OP;
  assign wr_last     = 1'b1;
  assign wr_bytemask = '0;

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_ready);

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R2
  wr_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(!msg_ready));

  // R9
  bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_bank == wr_addr[LINE_SH+BANK_W-1:LINE_SH]));
endmodule

// File: tb/msi_evq_writer_bench.sv
`timescale 1ns/1ps
module msi_evq_writer_bench;
  localparam int MSI_W = 8, QUEUE_W = 3, TAIL_W = 7;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic               msg_valid, msg_ready;
  logic [63:2]        msg_addr;
  logic [31:0]        msg_data;
  logic [15:0]        msg_rid;
  logic [63:0]        evq_base;
  logic               map_we, map_valid, pend_clr, head_we;
  logic [MSI_W-1:0]   map_idx, pend_clr_idx;
  logic [QUEUE_W-1:0] map_queue, head_sel;
  logic [TAIL_W-1:0]  head_val;
  logic               wr_valid, wr_last;
  logic [63:0]        wr_addr;
  logic [511:0]       wr_data;
  logic [3:0]         wr_opcode;
  logic [7:0]         wr_bytemask;
  logic [2:0]         wr_bank;

  msi_evq_writer #(.MSI_W(MSI_W), .QUEUE_W(QUEUE_W), .TAIL_W(TAIL_W)) u_msi_evq_writer (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_rid(msg_rid), .evq_base(evq_base),
    .map_we(map_we), .map_idx(map_idx), .map_valid(map_valid), .map_queue(map_queue),
    .pend_clr(pend_clr), .pend_clr_idx(pend_clr_idx), .head_we(head_we),
    .head_sel(head_sel), .head_val(head_val), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_opcode(wr_opcode), .wr_last(wr_last),
    .wr_bytemask(wr_bytemask), .wr_bank(wr_bank)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [255:0] mv, mp;
  logic [2:0]   mq [256];
  logic [6:0]   hd [8];
  logic [6:0]   tl [8];

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hdr_of(input logic [63:0] a, input logic [31:0] d,
                                         input logic [15:0] r);
    logic [6:0] f;
    f = (a[63:32] == 32'h0) ? 7'h58 : 7'h78;
    return {1'b0, f, 10'd1, a[15:2], r, d[15:0]};
  endfunction

  task automatic map_set(input int i, input bit v, input int q);
    @(negedge clk);
    map_we = 1'b1; map_idx = 8'(i); map_valid = v; map_queue = 3'(q);
    @(negedge clk);
    map_we = 1'b0;
    mv[i] = v; mq[i] = 3'(q);
  endtask

  task automatic clr(input int i);
    @(negedge clk);
    pend_clr = 1'b1; pend_clr_idx = 8'(i);
    @(negedge clk);
    pend_clr = 1'b0;
    mp[i] = 1'b0;
  endtask

  task automatic set_head(input int q, input logic [6:0] v);
    @(negedge clk);
    head_we = 1'b1; head_sel = 3'(q); head_val = v;
    @(negedge clk);
    head_we = 1'b0;
    hd[q] = v;
  endtask

  task automatic do_msg(input logic [63:0] a, input logic [31:0] d, input logic [15:0] r);
    int m;
    logic [2:0] q;
    bit acc;
    logic [63:0] ea;
    m = int'(d[7:0]);                   // R10: index is data[7:0]
    q = mq[m];
    acc = mv[m] && !mp[m] && (7'(tl[q] + 7'd1) != hd[q]);
    @(negedge clk);
    chk("R2 ready idle", msg_ready, 1);
    msg_valid = 1'b1; msg_addr = a[63:2]; msg_data = d; msg_rid = r;
    @(negedge clk);
    msg_valid = 1'b0;
    chk("R2 busy", msg_ready, 0);
    @(negedge clk);
    if (!acc) begin
      if (!mv[m])     chk("R3 unmapped drop", wr_valid, 0);
      else if (mp[m]) chk("R4 pending drop", wr_valid, 0);
      else            chk("R5 full drop", wr_valid, 0);
    end else begin
      ea = evq_base + {58'd0, q, 3'd0} * 64'd1024 + {57'd0, tl[q]} * 64'd64;
      chk("R2 write pulse", wr_valid, 1);
      chk("R6 address", wr_addr, ea);
      chk("R7 header word", wr_data[511:448], hdr_of(a, d, r));
      chk("R8 second word", wr_data[447:384], {a[63:16], d[31:16]});
      chk("R8 zero words", wr_data[383:0], 0);
      chk("R9 opcode/last/mask", {wr_opcode, wr_last, wr_bytemask}, {4'b1101, 1'b1, 8'h00});
      chk("R9 bank", wr_bank, ea[8:6]);
      mp[m] = 1'b1;
      tl[q] = tl[q] + 7'd1;
    end
  endtask

  initial begin
    #(10ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] a;
    logic [31:0] d;
    int sel;
    void'($urandom(32'd4711));
    mv = '0; mp = '0;
    for (int i = 0; i < 256; i++) mq[i] = 3'd0;
    for (int i = 0; i < 8; i++) begin hd[i] = 7'd0; tl[i] = 7'd0; end
    msg_valid = 0; msg_addr = '0; msg_data = '0; msg_rid = '0;
    evq_base = 64'h0000_00A0_0000_0000;
    map_we = 0; map_idx = '0; map_valid = 0; map_queue = '0;
    pend_clr = 0; pend_clr_idx = '0; head_we = 0; head_sel = '0; head_val = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", msg_ready, 1);
    chk("R1 reset wr_valid", wr_valid, 0);
    do_msg(64'h0000_0000_FEE0_1000, 32'h0000_0003, 16'h0100);  // R1/R3 unmapped

    // R7 narrow then wide header; R4 pending and clear
    map_set(3, 1, 2);
    do_msg(64'h0000_0000_FEE0_1234, 32'hCAFE_0003, 16'h0A0B);
    do_msg(64'h0000_0000_FEE0_1234, 32'hCAFE_0003, 16'h0A0B);
    clr(3);
    do_msg(64'h1234_5678_9ABC_DEF0, 32'h5555_AA03, 16'hBEEF);

    // R3 explicitly invalid entry
    map_set(9, 0, 1);
    do_msg(64'h0000_0000_0000_0040, 32'h0000_0009, 16'h0001);

    // R10 same low byte, different upper bits
    map_set(5, 1, 1);
    do_msg(64'h0000_0000_0000_0080, 32'h0000_0105, 16'h0002);
    do_msg(64'h0000_0000_0000_0080, 32'h7777_AA05, 16'h0003);

    // R5 full queue and head release
    map_set(20, 1, 4);
    set_head(4, 7'd3);
    do_msg(64'h0000_0000_0000_1000, 32'h0000_0014, 16'h0004);
    clr(20);
    do_msg(64'h0000_0000_0000_1000, 32'h0000_0014, 16'h0004);
    clr(20);
    do_msg(64'h0000_0000_0000_1000, 32'h0000_0014, 16'h0004);   // full
    set_head(4, 7'd4);
    do_msg(64'h0000_0000_0000_1000, 32'h0000_0014, 16'h0004);

    // R6 tail wrap on queue 7
    map_set(40, 1, 7);
    for (int k = 0; k < 130; k++) begin
      clr(40);
      set_head(7, 7'(tl[7] + 7'd64));
      a = {($urandom_range(0, 1) == 1) ? 32'($urandom) : 32'h0, 32'($urandom)};
      do_msg(a, {24'($urandom), 8'd40}, 16'($urandom));
    end

    // random mix
    for (int k = 0; k < 500; k++) begin
      sel = int'($urandom_range(0, 99));
      if (sel < 55) begin
        a = {($urandom_range(0, 1) == 1) ? 32'($urandom) : 32'h0, 32'($urandom)};
        d = {24'($urandom), 8'($urandom_range(0, 31))};
        do_msg(a, d, 16'($urandom));
      end else if (sel < 70) begin
        map_set(int'($urandom_range(0, 31)), ($urandom_range(0, 3) != 0),
                int'($urandom_range(0, 7)));
      end else if (sel < 88) begin
        clr(int'($urandom_range(0, 31)));
      end else if (sel < 97) begin
        set_head(int'($urandom_range(0, 7)), 7'($urandom));
      end else begin
        @(negedge clk);
        evq_base = {32'($urandom), 32'($urandom)} & 64'hFFFF_FFFF_FFFF_0000;
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule